// File: doc/BRIEF.md
# Dual External Interrupt Request Detector

This block turns two raw, active-low interrupt pins into two interrupt request flags for an interrupt controller. Each channel has a trigger-type input. With the type set to edge, a high-to-low transition on the pin latches a request flag. That flag stays set until the controller acknowledges the request or software writes the flag. With the type set to level, the request simply mirrors the inverted pin, so a pin that stays low keeps requesting service for as long as it stays low.

Each pin first crosses into the clock domain through a chain of synchroniser flops. A one-flop delayed copy of the synchronised level is then used to find falling edges. The acknowledge input, the software write strobe and the write data are separate per channel. Bit i of every vector port belongs to channel i, with channel 0 in bit 0. Priority resolution, vectoring and the processor are outside the block.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset (synchronous, active high) is applied, and on the cycle after it, both request outputs are 0. The synchronisers reset to the idle-high pin level.
- R2: In edge mode (type bit = 1), a pin that goes low after being high sets the request. The request is first visible after the third rising clock edge that samples the low pin: two synchroniser stages plus the flag register.
- R3: In edge mode, a set request stays set while there is no acknowledge and no write, even after the pin returns high.
- R4: In edge mode, an acknowledge pulse with no write and no coincident edge clears the request on the following clock edge.
- R5: In edge mode, a detected edge in the same cycle as an acknowledge leaves the request set.
- R6: In level mode (type bit = 0), the request equals the inverted pin value sampled two clock edges earlier. A pin held low keeps the request at 1 for every cycle it stays low.
- R7: In level mode, acknowledge pulses and software writes have no effect on the request output.
- R8: In edge mode, a write strobe loads the write-data bit into the flag. A write takes precedence over a same-cycle acknowledge. A detected edge takes precedence over a same-cycle write of 0.
- R9: In edge mode, a pin held low produces one request only: once acknowledged, the flag stays clear until the pin goes high and falls again.
- R10: The two channels are independent. Stimulus on one channel never changes the other channel's request.
- R11: While a channel is in level mode, its latched edge flag is held clear. Switching that channel to edge mode with the pin steady therefore shows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | NUM_CH | Raw active-low interrupt pins, asynchronous |
| trig_edge | input | NUM_CH | Trigger type per channel: 1 = falling edge, 0 = low level |
| irq_ack | input | NUM_CH | Acknowledge pulses from the interrupt controller |
| flag_wr | input | NUM_CH | Software write strobe for the request flag |
| flag_wdata | input | NUM_CH | Value written to the request flag when its strobe is high |
| irq_req | output | NUM_CH | Interrupt request flag per channel |

## Verification
The assertions assume that the type bit, acknowledge and write inputs are synchronous to the clock. They also assume that the level-mode relation only holds once two clock edges have passed since reset, which the checker enforces with a settling counter rather than a long look into the past. The stimulus drives every input on the falling clock edge. It toggles pins only occasionally, so that edges, held-low intervals and coincidences with acknowledges and writes all occur. It also changes the type bit rarely, which exercises the mode switch without losing edge-mode history too often.

// File: rtl/eid_pkg.sv
package eid_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    typedef struct packed {
        logic ack;
        logic wr;
        logic wdata;
    } flag_cmd_t;

    localparam logic PIN_IDLE = 1'b1;

    // Next value of the latched edge flag.
    // Priority: level mode clears, then edge, then write, then acknowledge.
    function automatic logic flag_next(
        input trig_e     mode,
        input logic      hit,
        input flag_cmd_t cmd,
        input logic      cur
    );
        logic nxt;
        if (mode != TRIG_EDGE) begin
            nxt = 1'b0;
        end else if (hit) begin
            nxt = 1'b1;
        end else if (cmd.wr) begin
            nxt = cmd.wdata;
        end else if (cmd.ack) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/eid_fall_det.sv
module eid_fall_det
    import eid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= PIN_IDLE;
        end else begin
            prev <= lvl;
        end
    end

    assign fall = prev & ~lvl;

endmodule

// File: rtl/eid_channel.sv
module eid_channel
    import eid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_n,
    input  trig_e     mode,
    input  flag_cmd_t cmd,
    output logic      req,
    output logic      hit,
    output logic      latched
);

    logic pin_s;

    eid_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_n),
        .q   (pin_s)
    );

    eid_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (pin_s),
        .fall (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= 1'b0;
        end else begin
            latched <= flag_next(mode, hit, cmd, latched);
        end
    end

    always_comb begin
        if (mode == TRIG_EDGE) begin
            req = latched;
        end else begin
            req = ~pin_s;
        end
    end

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import eid_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_n,
    input  logic [NUM_CH-1:0] trig_edge,
    input  logic [NUM_CH-1:0] irq_ack,
    input  logic [NUM_CH-1:0] flag_wr,
    input  logic [NUM_CH-1:0] flag_wdata,
    output logic [NUM_CH-1:0] irq_req
);

    logic [NUM_CH-1:0] edge_hit;
    logic [NUM_CH-1:0] flag_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        flag_cmd_t cmd;
        trig_e     mode;

        assign cmd.ack   = irq_ack[ch];
        assign cmd.wr    = flag_wr[ch];
        assign cmd.wdata = flag_wdata[ch];
        assign mode      = trig_e'(trig_edge[ch]);

        eid_channel #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .pin_n   (irq_n[ch]),
            .mode    (mode),
            .cmd     (cmd),
            .req     (irq_req[ch]),
            .hit     (edge_hit[ch]),
            .latched (flag_q[ch])
        );
    end

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] irq_n,
    input logic [NUM_CH-1:0] trig_edge,
    input logic [NUM_CH-1:0] irq_ack,
    input logic [NUM_CH-1:0] flag_wr,
    input logic [NUM_CH-1:0] flag_wdata,
    input logic [NUM_CH-1:0] irq_req,
    input logic [NUM_CH-1:0] edge_hit,
    input logic [NUM_CH-1:0] flag_q
);

    logic [1:0] settle;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle <= 2'd0;
        end else if (settle != 2'd3) begin
            settle <= settle + 2'd1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> irq_req == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
            trig_edge[i] && edge_hit[i] |=> flag_q[i]);

        assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
            trig_edge[i] && flag_q[i] && !irq_ack[i] && !flag_wr[i] |=> flag_q[i]);

        assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
            trig_edge[i] && irq_ack[i] && !flag_wr[i] && !edge_hit[i] |=> !flag_q[i]);

        assert_edge_beats_ack_R5: assert property (@(posedge clk) disable iff (rst)
            trig_edge[i] && edge_hit[i] && irq_ack[i] |=> flag_q[i]);

        assert_write_loads_R8: assert property (@(posedge clk) disable iff (rst)
            trig_edge[i] && flag_wr[i] && !edge_hit[i] |=> flag_q[i] == $past(flag_wdata[i]));

        assert_level_idle_R11: assert property (@(posedge clk) disable iff (rst)
            !trig_edge[i] |=> !flag_q[i]);

        if (SYNC_STAGES == 2) begin : g_lvl
            // R6 and R7: level-mode request tracks the pin regardless of ack/write
            assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
                (settle >= 2'd2) && !trig_edge[i] |-> irq_req[i] == !$past(irq_n[i], 2));
        end
    end

endmodule

bind ext_irq_detect ext_irq_detect_chk #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_n      (irq_n),
    .trig_edge  (trig_edge),
    .irq_ack    (irq_ack),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .irq_req    (irq_req),
    .edge_hit   (edge_hit),
    .flag_q     (flag_q)
);

// File: tb/tb_ext_irq_detect.sv
`timescale 1ns/1ps
module tb_ext_irq_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pin_r = 2'b11;
    logic [1:0] sel_r = 2'b00;
    logic [1:0] ack_r = 2'b00;
    logic [1:0] wr_r  = 2'b00;
    logic [1:0] wd_r  = 2'b00;
    logic [1:0] irq_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0] m_s1 = 2'b11, m_s2 = 2'b11, m_s3 = 2'b11, m_flag = 2'b00;

    always #2.5 clk = ~clk;

    ext_irq_detect dut (
        .clk        (clk),
        .rst        (rst),
        .irq_n      (pin_r),
        .trig_edge  (sel_r),
        .irq_ack    (ack_r),
        .flag_wr    (wr_r),
        .flag_wdata (wd_r),
        .irq_req    (irq_req)
    );

    function automatic logic [1:0] model_req();
        logic [1:0] e;
        for (int i = 0; i < 2; i++) e[i] = sel_r[i] ? m_flag[i] : ~m_s2[i];
        return e;
    endfunction

    task automatic step(input logic [1:0] pin, input logic [1:0] sel,
                        input logic [1:0] ack, input logic [1:0] wr, input logic [1:0] wd);
        logic [1:0] hit;
        logic [1:0] nf;
        pin_r = pin; sel_r = sel; ack_r = ack; wr_r = wr; wd_r = wd;
        @(posedge clk);
        if (rst) begin
            m_s1 = 2'b11; m_s2 = 2'b11; m_s3 = 2'b11; m_flag = 2'b00;
        end else begin
            hit = m_s3 & ~m_s2;
            for (int i = 0; i < 2; i++) begin
                if (!sel[i])     nf[i] = 1'b0;
                else if (hit[i]) nf[i] = 1'b1;
                else if (wr[i])  nf[i] = wd[i];
                else if (ack[i]) nf[i] = 1'b0;
                else             nf[i] = m_flag[i];
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin; m_flag = nf;
        end
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk2(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        rst = 1'b1;
        repeat (3) step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
        chk2("R1 reset", irq_req, 2'b00);
        rst = 1'b0;
        step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
        chk2("R1 after reset", irq_req, 2'b00);

        // R2: falling edge on ch0, edge mode; ch1 level with pin high
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R2 not yet", irq_req[0], 1'b0);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R2 set", irq_req[0], 1'b1);
        // R3
        repeat (4) step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R3 latched", irq_req[0], 1'b1);
        // R4
        step(2'b11, 2'b01, 2'b01, 2'b00, 2'b00);
        chk("R4 ack clears", irq_req[0], 1'b0);
        // R9
        repeat (3) step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R9 first request", irq_req[0], 1'b1);
        step(2'b10, 2'b01, 2'b01, 2'b00, 2'b00);
        chk("R9 acked", irq_req[0], 1'b0);
        repeat (4) step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R9 held low no repeat", irq_req[0], 1'b0);
        // R8
        step(2'b10, 2'b01, 2'b00, 2'b01, 2'b01);
        chk("R8 write 1", irq_req[0], 1'b1);
        step(2'b10, 2'b01, 2'b01, 2'b01, 2'b00);
        chk("R8 write 0", irq_req[0], 1'b0);
        step(2'b10, 2'b01, 2'b01, 2'b01, 2'b01);
        chk("R8 write beats ack", irq_req[0], 1'b1);
        // R5
        repeat (3) step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b01, 2'b01, 2'b00, 2'b00);
        chk("R5 edge beats ack", irq_req[0], 1'b1);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R5 stays set", irq_req[0], 1'b1);
        // R8 edge beats write of 0
        repeat (3) step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b11, 2'b01, 2'b01, 2'b00, 2'b00);
        chk("R8 cleared before edge", irq_req[0], 1'b0);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b01, 2'b00, 2'b01, 2'b00);
        chk("R8 edge beats write 0", irq_req[0], 1'b1);

        // R6: ch1 level mode
        step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R6 delay", irq_req[1], 1'b0);
        step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R6 low seen", irq_req[1], 1'b1);
        repeat (3) step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R6 held low", irq_req[1], 1'b1);
        // R7
        step(2'b00, 2'b01, 2'b10, 2'b00, 2'b00);
        chk("R7 ack ignored", irq_req[1], 1'b1);
        step(2'b00, 2'b01, 2'b00, 2'b10, 2'b00);
        chk("R7 write 0 ignored", irq_req[1], 1'b1);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R6 release delay", irq_req[1], 1'b1);
        step(2'b10, 2'b01, 2'b00, 2'b00, 2'b00);
        chk("R6 released", irq_req[1], 1'b0);
        step(2'b10, 2'b01, 2'b00, 2'b10, 2'b10);
        chk("R7 write 1 ignored", irq_req[1], 1'b0);
        // R11
        repeat (3) step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b00, 2'b11, 2'b00, 2'b00, 2'b00);
        chk("R11 switch shows no request", irq_req[1], 1'b0);
        repeat (3) step(2'b10, 2'b11, 2'b00, 2'b00, 2'b00);
        repeat (3) step(2'b00, 2'b11, 2'b00, 2'b00, 2'b00);
        chk("R11 edge mode active", irq_req[1], 1'b1);
        // R10
        step(2'b00, 2'b11, 2'b01, 2'b00, 2'b00);
        chk2("R10 ack ch0 only", irq_req, 2'b10);

        // Random phase against the bench model (R2..R11, R10 independence)
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] p, s, a, w, d;
            p = pin_r; s = sel_r;
            for (int i = 0; i < 2; i++) begin
                if ($urandom % 8 == 0)  p[i] = ~p[i];
                if ($urandom % 64 == 0) s[i] = ~s[i];
                a[i] = ($urandom % 6 == 0);
                w[i] = ($urandom % 16 == 0);
                d[i] = $urandom % 2;
            end
            step(p, s, a, w, d);
            chk2("R10 random vs model", irq_req, model_req());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule